// File: doc/BRIEF.md
# Matrix Keypad Scanner (4 rows by 4 columns)

This block scans a sixteen-key matrix keypad through one 8-bit port. The four row lines sit in the upper half of the port and the four column levels come back on a separate 4-bit input. While waiting for a key, the block holds all row lines low and watches the columns. Any column that reads low means a key is down. The block then waits until that column reading has stayed unchanged for a set number of cycles. Next it raises one row line at a time, in a fixed order. The first row whose column reading differs from the captured one is the row of the pressed key.

For that key the block gives a one-cycle strobe together with an 8-bit code. The top three rows produce ASCII characters and the bottom row produces four command codes. After a strobe the block does not accept a new press until every column has read high for the same debounce span. Holding a key down therefore gives exactly one report.

Top module: `keypad_matrix_scanner`

## Requirements
- R1: After reset the port reads 0x0F: all row lines low and the lower half high. `key_valid` is low.
- R2: While waiting, a column reading of 1111 means no key is down. Any other reading starts a press, and that reading is captured.
- R3: A press is scanned only if the column input equals the captured reading for DEB_CYCLES consecutive cycles. A change before that drops the press: no rows are probed and no strobe is issued.
- R4: Scanning drives 0x1F, 0x2F, 0x4F, 0x8F on the port in that order, one pattern per cycle. At most one row bit (bits 7..4) is ever high, and bits 3..0 always read 1111.
- R5: The reported row is the first probed row whose column reading differs from the captured reading. Scanning stops at that row.
- R6: Within the reported row, the key is the lowest-numbered column (bit 0 first) that was low in the captured reading and reads high during that probe.
- R7: Row 0, columns 0..3 give 0x31..0x34 ('1'..'4'). Row 1 gives 0x35..0x38 ('5'..'8'). Row 2 gives 0x39, 0x30, 0x61, 0x62 ('9', '0', 'a', 'b').
- R8: Row 3, columns 0..3 give the command codes 0x0D (enter), 0x11 (change password), 0x12 (save) and 0x13 (cursor/display).
- R9: Each accepted press gives exactly one `key_valid` pulse, one cycle long, however long the key is held. The row lines are all low during the pulse.
- R10: After a scan, a new press is accepted only after the columns have read 1111 for DEB_CYCLES consecutive cycles. A shorter release followed by a new press gives no second strobe.
- R11: If no probed row changes the column reading, no strobe is issued, and the block waits for release as in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_in | input | 4 | Column levels; low means a key connects the column to a low row line |
| port_out | output | 8 | Bits 7..4 are the row lines and bits 3..0 are held high |
| key_valid | output | 1 | One-cycle strobe for a decoded key |
| key_code | output | 8 | Character or command code, valid while `key_valid` is high |

## Verification
A wrong row counter or state shows up at once at the port. A probe pattern appears out of order, more than one row bit is high, or the row lines are not low during a strobe. The debounce and rearm counters are checked by timing: a short bounce or a short release must produce no strobe, and a held key must produce no second strobe. A wrong mapping or column priority shows up within the first scan of the affected key, as a code that differs from the expected one.

// File: rtl/kms_pkg.sv
package kms_pkg;

   typedef enum logic [1:0] {
      ST_WAIT   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_PROBE  = 2'd2,
      ST_DRAIN  = 2'd3
   } kms_state_t;

   localparam logic [7:0] CMD_ENTER  = 8'h0D;
   localparam logic [7:0] CMD_NEWPW  = 8'h11;
   localparam logic [7:0] CMD_SAVE   = 8'h12;
   localparam logic [7:0] CMD_CURSOR = 8'h13;

   function automatic logic [7:0] kms_map(input logic [1:0] r, input logic [1:0] c);
      logic [7:0] v;
      case (r)
         2'd0:    v = 8'h31 + {6'd0, c};
         2'd1:    v = 8'h35 + {6'd0, c};
         2'd2: begin
            case (c)
               2'd0:    v = 8'h39;
               2'd1:    v = 8'h30;
               2'd2:    v = 8'h61;
               default: v = 8'h62;
            endcase
         end
         default: begin
            case (c)
               2'd0:    v = CMD_ENTER;
               2'd1:    v = CMD_NEWPW;
               2'd2:    v = CMD_SAVE;
               default: v = CMD_CURSOR;
            endcase
         end
      endcase
      return v;
   endfunction

endpackage

// File: rtl/kms_stable_timer.sv
module kms_stable_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

   logic [CNT_W-1:0] cnt_q;

   assign done = run && (cnt_q == CNT_W'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || done)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/kms_row_driver.sv
module kms_row_driver #(
   parameter int NUM_ROWS = 4,
   localparam int RIW = (NUM_ROWS < 2) ? 1 : $clog2(NUM_ROWS)
) (
   input  logic               probe_en,
   input  logic [RIW-1:0]     row_idx,
   output logic [NUM_ROWS-1:0] row_lines
);
   for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
      assign row_lines[g] = probe_en && (row_idx == RIW'(g));
   end
endmodule

// File: rtl/kms_col_pick.sv
module kms_col_pick #(
   parameter int NUM_COLS = 4,
   localparam int CIW = (NUM_COLS < 2) ? 1 : $clog2(NUM_COLS)
) (
   input  logic [NUM_COLS-1:0] held,
   input  logic [NUM_COLS-1:0] probed,
   output logic                found,
   output logic [CIW-1:0]      col_idx
);
   logic [NUM_COLS-1:0] cand;
   logic [NUM_COLS-1:0] first;
   logic [NUM_COLS:0]   seen;

   assign cand    = ~held & probed;
   assign seen[0] = 1'b0;

   for (genvar g = 0; g < NUM_COLS; g++) begin : g_chain
      assign first[g]  = cand[g] & ~seen[g];
      assign seen[g+1] = seen[g] | cand[g];
   end

   assign found = seen[NUM_COLS];

   always_comb begin
      col_idx = '0;
      for (int i = 0; i < NUM_COLS; i++)
         if (first[i]) col_idx = col_idx | CIW'(i);
   end
endmodule

// File: rtl/keypad_matrix_scanner.sv
module keypad_matrix_scanner #(
   parameter int NUM_ROWS   = 4,
   parameter int NUM_COLS   = 4,
   parameter int DEB_CYCLES = 20000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] col_in,
   output logic [7:0] port_out,
   output logic       key_valid,
   output logic [7:0] key_code
);
   import kms_pkg::*;

   localparam int RIW = (NUM_ROWS < 2) ? 1 : $clog2(NUM_ROWS);
   localparam int CIW = (NUM_COLS < 2) ? 1 : $clog2(NUM_COLS);
   localparam logic [RIW-1:0]      LAST_ROW = RIW'(NUM_ROWS - 1);
   localparam logic [NUM_COLS-1:0] ALL_HIGH = '1;

   if (NUM_ROWS != 4 || NUM_COLS != 4) begin : g_bad_shape
      $error("keypad_matrix_scanner: the code map needs a 4x4 matrix");
   end
   if (DEB_CYCLES < 1) begin : g_bad_deb
      $error("keypad_matrix_scanner: DEB_CYCLES must be at least 1");
   end

   kms_state_t           state_q;
   logic [RIW-1:0]       row_q;
   logic [NUM_COLS-1:0]  snap_q;
   logic                 valid_q;
   logic [7:0]           code_q;

   logic                 t_run;
   logic                 t_done;
   logic [NUM_ROWS-1:0]  rows;
   logic                 pick_found;
   logic [CIW-1:0]       pick_idx;

   assign t_run = ((state_q == ST_SETTLE) && (col_in == snap_q)) ||
                  ((state_q == ST_DRAIN)  && (col_in == ALL_HIGH));

   kms_stable_timer #(.LIMIT(DEB_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (t_run),
      .done  (t_done)
   );

   kms_row_driver #(.NUM_ROWS(NUM_ROWS)) u_rows (
      .probe_en  (state_q == ST_PROBE),
      .row_idx   (row_q),
      .row_lines (rows)
   );

   kms_col_pick #(.NUM_COLS(NUM_COLS)) u_pick (
      .held    (snap_q),
      .probed  (col_in),
      .found   (pick_found),
      .col_idx (pick_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_WAIT;
         row_q   <= '0;
         snap_q  <= ALL_HIGH;
         valid_q <= 1'b0;
         code_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         case (state_q)
            ST_WAIT: begin
               if (col_in != ALL_HIGH) begin
                  snap_q  <= col_in;
                  state_q <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (col_in != snap_q)
                  state_q <= ST_WAIT;
               else if (t_done) begin
                  row_q   <= '0;
                  state_q <= ST_PROBE;
               end
            end
            ST_PROBE: begin
               if (col_in != snap_q) begin
                  state_q <= ST_DRAIN;
                  if (pick_found) begin
                     valid_q <= 1'b1;
                     code_q  <= kms_map(2'(row_q), 2'(pick_idx));
                  end
               end else if (row_q == LAST_ROW) begin
                  state_q <= ST_DRAIN;
               end else begin
                  row_q <= row_q + 1'b1;
               end
            end
            default: begin
               if (t_done) state_q <= ST_WAIT;
            end
         endcase
      end
   end

   assign port_out  = {rows, ALL_HIGH};
   assign key_valid = valid_q;
   assign key_code  = code_q;

endmodule

// File: rtl/kms_chk.sv
module kms_chk #(
   parameter int DEB_CYCLES = 20000
) (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] col_in,
   input logic [7:0] port_out,
   input logic       key_valid,
   input logic [7:0] key_code
);
   localparam int SW = $clog2(DEB_CYCLES + 3) + 1;
   localparam logic [SW-1:0] SAT = SW'(DEB_CYCLES + 1);

   logic [3:0]    col_prev_q;
   logic [SW-1:0] stab_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_prev_q <= 4'hF;
         stab_q     <= '0;
      end else begin
         col_prev_q <= col_in;
         if (port_out[7:4] == 4'h0 && col_in != 4'hF) begin
            if (col_in != col_prev_q) stab_q <= SW'(1);
            else if (stab_q != SAT)   stab_q <= stab_q + 1'b1;
         end else begin
            stab_q <= '0;
         end
      end
   end

   function automatic logic legal_code(input logic [7:0] v);
      case (v)
         8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37,
         8'h38, 8'h39, 8'h61, 8'h62, 8'h0D, 8'h11, 8'h12, 8'h13: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   a_r4_port_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (port_out[3:0] == 4'hF) && $onehot0(port_out[7:4]));

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |=> !key_valid);

   a_r9_rows_low: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |-> (port_out[7:4] == 4'h0));

   a_r5_probe_first: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |-> ($past(port_out[7:4]) != 4'h0));

   a_r7_code_set: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |-> legal_code(key_code));

   a_r3_debounce_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|port_out[7:4]) |-> (stab_q >= SW'(DEB_CYCLES)));

endmodule

bind keypad_matrix_scanner kms_chk #(.DEB_CYCLES(DEB_CYCLES)) u_kms_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .col_in    (col_in),
   .port_out  (port_out),
   .key_valid (key_valid),
   .key_code  (key_code)
);

// File: tb/keypad_matrix_scanner_test.sv
module keypad_matrix_scanner_test;
   localparam int DEB = 8;
   localparam int HOLD = DEB + 14;
   localparam int GAP = DEB + 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] col_in;
   logic [7:0] port_out;
   logic       key_valid;
   logic [7:0] key_code;

   logic [15:0] pressed = '0;
   logic [3:0]  stuck = '0;

   int total = 0;
   int bad = 0;
   int strobes = 0;
   int cyc = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] pat_q[$];

   always #10 clk = ~clk;

   keypad_matrix_scanner #(.DEB_CYCLES(DEB)) uut (
      .clk(clk), .rst_n(rst_n), .col_in(col_in),
      .port_out(port_out), .key_valid(key_valid), .key_code(key_code)
   );

   // keypad model: a closed key pulls its column low when its row line is low
   always_comb begin
      for (int c = 0; c < 4; c++) begin
         col_in[c] = ~stuck[c];
         for (int r = 0; r < 4; r++)
            if (pressed[r*4+c] && !port_out[4+r]) col_in[c] = 1'b0;
      end
   end

   function automatic logic [7:0] expect_code(int r, int c);
      logic [7:0] t [16];
      t = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38,
            8'h39, 8'h30, 8'h61, 8'h62, 8'h0D, 8'h11, 8'h12, 8'h13};
      return t[r*4+c];
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic end_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // monitor: pops the scoreboard on each strobe
   always @(negedge clk) begin
      if (rst_n) begin
         if (port_out != 8'h0F) pat_q.push_back(port_out);
         if (key_valid) begin
            strobes++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected strobe", key_code, 0);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(key_code == e, t, "key code", key_code, e);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         check(1'b0, "WATCHDOG", "run timed out", cyc, 60000);
         end_run();
      end
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_exp(logic [7:0] v, string tag);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   task automatic press(int r, int c, int hold, string tag);
      push_exp(expect_code(r, c), tag);
      pressed[r*4+c] = 1'b1;
      wait_cyc(hold);
      pressed = '0;
      wait_cyc(GAP);
   endtask

   initial begin
      int s0;
      wait_cyc(4);
      check(port_out == 8'h0F, "R1", "port after reset", port_out, 8'h0F);
      check(key_valid == 1'b0, "R1", "strobe after reset", key_valid, 0);
      rst_n = 1'b1;
      wait_cyc(3);
      check(port_out == 8'h0F, "R2", "idle with no key", port_out, 8'h0F);

      // R7 / R8: every key through the map
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++)
            press(r, c, HOLD, (r < 3) ? "R7" : "R8");

      // R4: full probe order for a bottom-row key
      pat_q.delete();
      press(3, 1, HOLD, "R8");
      check(pat_q.size() == 4, "R4", "probe count", pat_q.size(), 4);
      if (pat_q.size() == 4) begin
         check(pat_q[0] == 8'h1F, "R4", "probe 0", pat_q[0], 8'h1F);
         check(pat_q[1] == 8'h2F, "R4", "probe 1", pat_q[1], 8'h2F);
         check(pat_q[2] == 8'h4F, "R4", "probe 2", pat_q[2], 8'h4F);
         check(pat_q[3] == 8'h8F, "R4", "probe 3", pat_q[3], 8'h8F);
      end

      // R5: scanning stops at the row found
      pat_q.delete();
      press(1, 3, HOLD, "R5");
      check(pat_q.size() == 2, "R5", "probes for row 1", pat_q.size(), 2);

      // R3: bounce shorter than the window
      s0 = strobes;
      pat_q.delete();
      pressed[5] = 1'b1;
      wait_cyc(DEB - 3);
      pressed = '0;
      wait_cyc(2 * DEB);
      check(strobes == s0, "R3", "strobes after bounce", strobes, s0);
      check(pat_q.size() == 0, "R3", "probes after bounce", pat_q.size(), 0);

      // R6: two keys in one row, lowest column wins
      push_exp(expect_code(2, 1), "R6");
      pressed[2*4+1] = 1'b1;
      pressed[2*4+3] = 1'b1;
      wait_cyc(HOLD);
      pressed = '0;
      wait_cyc(GAP);

      // R5 / R6: keys in two rows, upper row reported
      push_exp(expect_code(1, 2), "R5");
      pressed[1*4+2] = 1'b1;
      pressed[2*4+0] = 1'b1;
      wait_cyc(HOLD);
      pressed = '0;
      wait_cyc(GAP);

      // R9: long hold gives one strobe
      s0 = strobes;
      press(0, 2, 300, "R9");
      check(strobes == s0 + 1, "R9", "strobes on long hold", strobes, s0 + 1);

      // R10: short release does not rearm
      s0 = strobes;
      push_exp(expect_code(1, 1), "R10");
      pressed[1*4+1] = 1'b1;
      wait_cyc(HOLD);
      pressed = '0;
      wait_cyc(DEB - 3);
      pressed[1*4+1] = 1'b1;
      wait_cyc(HOLD);
      pressed = '0;
      wait_cyc(GAP);
      check(strobes == s0 + 1, "R10", "strobes over short release", strobes, s0 + 1);
      press(1, 1, HOLD, "R10");

      // R11: a column held low by no key yields no strobe
      s0 = strobes;
      pat_q.delete();
      stuck = 4'b0100;
      wait_cyc(3 * DEB);
      check(strobes == s0, "R11", "strobes with phantom column", strobes, s0);
      check(pat_q.size() == 4, "R11", "probes with phantom column", pat_q.size(), 4);
      stuck = '0;
      wait_cyc(GAP);
      check(port_out == 8'h0F, "R11", "port after phantom", port_out, 8'h0F);
      press(0, 0, HOLD, "R11");

      check(exp_q.size() == 0, "R9", "missing strobes", exp_q.size(), 0);
      end_run();
   end
endmodule